// File: doc/BRIEF.md
# Debug Trace Line Packer

The block turns a stream of CPU debug events into eight-byte lines for a circular trace memory. A two-bit mode input selects one of two capture formats. The three compact modes (normal, loop and pure program-counter capture) all use a four-byte entry made of an info byte and a 24-bit program counter. Two such entries share one line. The first entry of a pair waits in a staging register until the second one arrives. The detailed mode fills a whole line with one event: two info bytes, a 24-bit address and two data lanes whose contents depend on the access width.

An entry counter tracks progress through the memory. Its bit 0 selects the half-line in the compact modes, and it stays zero in the detailed mode. Bits above it form the line pointer. Each committed line appears on a registered write port, with a line address, 64 bits of data and an enable. The same clock edge sets that line's valid flag and a flag that tells whether the line holds a pair. A sticky overflow flag records that the pointer has wrapped past the last line. A flush input commits a half-filled pair line on its own.

Top module: `trace_line_packer`

## Requirements
- R1: After reset the counter, the write enable, every line valid flag, every pair flag and the overflow flag are all zero.
- R2: Mode codes 0, 1 and 2 are compact. In these modes an event with counter bit 0 clear is only staged: no line is written and the counter advances by one, so bit 0 becomes 1.
- R3: A compact event with counter bit 0 set writes one line at address counter[6:1]. Bits [31:0] hold the staged entry and bits [63:32] hold the new entry, each entry packed as {info[7:0], pc[23:0]}. The line's pair flag is set, and the counter advances by one.
- R4: Compact modes 0, 1 and 2 produce identical lines, counter steps and flags for identical events.
- R5: In detailed mode (code 3) every event writes one line at address counter[6:1]. The counter advances by two, and its bit 0 stays zero.
- R6: A detailed byte access (word input low) puts data[7:0] in line byte 2 (bits [23:16]) and zero in byte 3 (bits [31:24]). The full line is {info, addr[23:0], byte3, byte2, info2, 8'h00}, and its pair flag is cleared.
- R7: A detailed word access puts data[15:8], the byte at the lower address, in byte 3, and data[7:0], the byte at the higher address, in byte 2.
- R8: Every written line sets its valid flag on the same edge that raises the write enable, and valid flags never clear outside reset.
- R9: A flush in a compact mode, with no event that cycle and counter bit 0 set, writes {32'h0, staged entry}, clears the pair flag and advances the counter by one. A flush in any other situation changes nothing.
- R10: A cycle whose mode differs from the previous cycle's mode clears the counter and drops any staged entry before that cycle's event is applied.
- R11: The pointer wraps from line 63 to line 0. Writing line 63 sets the overflow flag, which then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 normal, 1 loop, 2 pure PC, 3 detailed |
| evt_i | input | 1 | Event strobe |
| evt_info_i | input | 8 | Primary info byte |
| evt_info2_i | input | 8 | Second info byte (detailed mode) |
| evt_addr_i | input | 24 | Program counter or bus address |
| evt_data_i | input | 16 | Access data, [15:8] from the lower address |
| evt_word_i | input | 1 | Word access when high, byte access when low |
| flush_i | input | 1 | Commit a half-filled compact line |
| wr_en_o | output | 1 | Line write strobe |
| wr_addr_o | output | 6 | Line address |
| wr_data_o | output | 64 | Line contents |
| cnt_o | output | 7 | Entry counter |
| line_vld_o | output | 64 | Per-line valid flags |
| line_pair_o | output | 64 | Per-line two-entry flags |
| ovf_o | output | 1 | Sticky wrap flag |

## Verification
Each compact mode receives a run of events with different info and counter patterns. This shows whether staging, half-line placement and counter steps agree across the modes, and whether the three modes differ from one another. The detailed mode receives events that alternate between byte and word accesses, which separates the two lane-placement rules. Flush cases are tried with a staged entry, with no staged entry, together with an event, and in detailed mode, so a commit can be told apart from a flush that is ignored. Long runs in both formats push the pointer past line 63 to exercise the wrap and the sticky overflow flag. A mode switch is made in the middle of a pair to show that the counter is cleared and the staged entry is dropped.

// File: rtl/tlp_pkg.sv
package tlp_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_LOOP   = 2'd1,
    MODE_PUREPC = 2'd2,
    MODE_DETAIL = 2'd3
  } tlp_mode_e;

  localparam int INFO_W = 8;
  localparam int ADR_W  = 24;
  localparam int DAT_W  = 16;
  localparam int HALF_W = INFO_W + ADR_W;
  localparam int LINE_W = 2 * HALF_W;
endpackage

// File: rtl/tlp_format.sv
module tlp_format
  import tlp_pkg::*;
(
  input  logic [INFO_W-1:0] info_i,
  input  logic [INFO_W-1:0] info2_i,
  input  logic [ADR_W-1:0]  addr_i,
  input  logic [DAT_W-1:0]  data_i,
  input  logic              word_i,
  output logic [HALF_W-1:0] half_o,
  output logic [LINE_W-1:0] det_line_o
);
  localparam int BYTE_W = DAT_W / 2;

  logic [BYTE_W-1:0] lane_hi;
  logic [BYTE_W-1:0] lane_lo;

  always_comb begin
    half_o  = {info_i, addr_i};
    // lower-address byte lands in byte 3, higher-address byte in byte 2
    lane_hi = word_i ? data_i[DAT_W-1:BYTE_W] : '0;
    lane_lo = data_i[BYTE_W-1:0];
    det_line_o = {info_i, addr_i, lane_hi, lane_lo, info2_i, {BYTE_W{1'b0}}};
  end
endmodule

// File: rtl/tlp_sequencer.sv
module tlp_sequencer
  import tlp_pkg::*;
#(
  parameter int PTR_W = 6,
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              evt_i,
  input  logic              flush_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [LINE_W-1:0] det_line_i,
  output logic              commit_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              pair_o,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [LINE_W-1:0] wr_data_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o
);
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PTR_W-1:0] PTR_LAST = {PTR_W{1'b1}};

  logic [1:0]        mode_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n, base_cnt;
  logic [HALF_W-1:0] stage_q, stage_n;
  logic              ovf_q, ovf_n;
  logic              wr_en_q;
  logic [PTR_W-1:0]  wr_addr_q;
  logic [LINE_W-1:0] wr_data_q;
  logic              mode_chg, is_det;
  logic              commit_n, pair_n;
  logic [LINE_W-1:0] line_n;
  logic [PTR_W-1:0]  ptr_n;
  logic              cnt_en, stage_en;

  always_comb begin
    mode_chg = (mode_i != mode_q);
    is_det   = (mode_i == MODE_DETAIL);
    base_cnt = mode_chg ? '0 : cnt_q;
    ptr_n    = base_cnt[CNT_W-1:1];
    cnt_n    = base_cnt;
    stage_n  = stage_q;
    commit_n = 1'b0;
    pair_n   = 1'b0;
    line_n   = '0;
    if (evt_i) begin
      if (is_det) begin
        commit_n = 1'b1;
        line_n   = det_line_i;
        cnt_n    = {ptr_n + PTR_ONE, 1'b0};
      end else if (!base_cnt[0]) begin
        stage_n = half_i;
        cnt_n   = base_cnt + CNT_ONE;
      end else begin
        commit_n = 1'b1;
        pair_n   = 1'b1;
        line_n   = {half_i, stage_q};
        cnt_n    = base_cnt + CNT_ONE;
      end
    end else if (flush_i && !is_det && base_cnt[0]) begin
      commit_n = 1'b1;
      line_n   = {{HALF_W{1'b0}}, stage_q};
      cnt_n    = base_cnt + CNT_ONE;
    end
    ovf_n    = ovf_q | (commit_n && (ptr_n == PTR_LAST));
    cnt_en   = evt_i | flush_i | mode_chg;
    stage_en = evt_i & ~is_det;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_NORMAL;
      cnt_q     <= '0;
      stage_q   <= '0;
      ovf_q     <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      mode_q  <= mode_i;
      wr_en_q <= commit_n;
      ovf_q   <= ovf_n;
      if (cnt_en)   cnt_q   <= cnt_n;
      if (stage_en) stage_q <= stage_n;
      if (commit_n) begin
        wr_addr_q <= ptr_n;
        wr_data_q <= line_n;
      end
    end
  end

  assign commit_o  = commit_n;
  assign ptr_o     = ptr_n;
  assign pair_o    = pair_n;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign cnt_o     = cnt_q;
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/tlp_flagbank.sv
module tlp_flagbank #(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             pair_i,
  output logic [DEPTH-1:0] vld_o,
  output logic [DEPTH-1:0] pair_o
);
  logic [DEPTH-1:0] vld_q, pair_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_line
    logic hit;
    assign hit = commit_i && (ptr_i == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g]  <= 1'b0;
        pair_q[g] <= 1'b0;
      end else if (hit) begin
        vld_q[g]  <= 1'b1;
        pair_q[g] <= pair_i;
      end
    end
  end

  assign vld_o  = vld_q;
  assign pair_o = pair_q;
endmodule

// File: rtl/trace_line_packer.sv
module trace_line_packer
  import tlp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              evt_i,
  input  logic [7:0]        evt_info_i,
  input  logic [7:0]        evt_info2_i,
  input  logic [23:0]       evt_addr_i,
  input  logic [15:0]       evt_data_i,
  input  logic              evt_word_i,
  input  logic              flush_i,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [63:0]       wr_data_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DEPTH-1:0]  line_vld_o,
  output logic [DEPTH-1:0]  line_pair_o,
  output logic              ovf_o
);
  logic [HALF_W-1:0] half;
  logic [LINE_W-1:0] det_line;
  logic              commit;
  logic [PTR_W-1:0]  ptr;
  logic              pair;

  tlp_format u_fmt (
    .info_i     (evt_info_i),
    .info2_i    (evt_info2_i),
    .addr_i     (evt_addr_i),
    .data_i     (evt_data_i),
    .word_i     (evt_word_i),
    .half_o     (half),
    .det_line_o (det_line)
  );

  tlp_sequencer #(.PTR_W(PTR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .evt_i      (evt_i),
    .flush_i    (flush_i),
    .half_i     (half),
    .det_line_i (det_line),
    .commit_o   (commit),
    .ptr_o      (ptr),
    .pair_o     (pair),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .cnt_o      (cnt_o),
    .ovf_o      (ovf_o)
  );

  tlp_flagbank #(.DEPTH(DEPTH)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (commit),
    .ptr_i    (ptr),
    .pair_i   (pair),
    .vld_o    (line_vld_o),
    .pair_o   (line_pair_o)
  );
endmodule

// File: rtl/tlp_checker.sv
module tlp_checker #(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             evt_i,
  input logic [15:0]      evt_data_i,
  input logic             evt_word_i,
  input logic             flush_i,
  input logic             wr_en_o,
  input logic [PTR_W-1:0] wr_addr_o,
  input logic [63:0]      wr_data_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic [DEPTH-1:0] line_vld_o,
  input logic [DEPTH-1:0] line_pair_o,
  input logic             ovf_o
);
  logic [1:0] prev_mode;
  logic       same_mode, det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_mode <= 2'd0;
    else        prev_mode <= mode_i;
  end

  assign same_mode = (mode_i == prev_mode);
  assign det       = (mode_i == 2'd3);

  // R2
  stage_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i && !det && (!same_mode || !cnt_o[0]) |=> !wr_en_o && cnt_o[0]);

  // R3
  pair_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i && !det && same_mode && cnt_o[0] |=> wr_en_o && line_pair_o[wr_addr_o]);

  // R5
  detail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i && det && same_mode |=> wr_en_o && !cnt_o[0] && (cnt_o == $past(cnt_o) + CNT_W'(2)));

  // R6
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i && det && !evt_word_i |=> (wr_data_o[31:24] == 8'h00) && (wr_data_o[23:16] == $past(evt_data_i[7:0])));

  // R7
  word_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i && det && evt_word_i |=> (wr_data_o[31:24] == $past(evt_data_i[15:8])) && (wr_data_o[23:16] == $past(evt_data_i[7:0])));

  // R8
  vld_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> line_vld_o[wr_addr_o]);

  // R8
  vld_never_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~line_vld_o & $past(line_vld_o)) == '0));

  // R9
  flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i && !evt_i && same_mode && !cnt_o[0] |=> !wr_en_o && $stable(cnt_o));

  // R10
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !same_mode && !evt_i && !flush_i |=> (cnt_o == '0));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
endmodule

bind trace_line_packer tlp_checker #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .evt_i       (evt_i),
  .evt_data_i  (evt_data_i),
  .evt_word_i  (evt_word_i),
  .flush_i     (flush_i),
  .wr_en_o     (wr_en_o),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o),
  .cnt_o       (cnt_o),
  .line_vld_o  (line_vld_o),
  .line_pair_o (line_pair_o),
  .ovf_o       (ovf_o)
);

// File: tb/trace_line_packer_test.sv
module trace_line_packer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        evt, word, flush;
  logic [7:0]  info, info2;
  logic [23:0] addr;
  logic [15:0] data;
  logic        wr_en;
  logic [5:0]  wr_addr;
  logic [63:0] wr_data;
  logic [6:0]  cnt;
  logic [63:0] vld, pair;
  logic        ovf;

  int nchk = 0;
  int nbad = 0;

  // model state
  logic [1:0]  m_prev;
  logic [6:0]  m_cnt;
  logic [31:0] m_stage;
  logic [63:0] m_vld, m_pair;
  logic        m_ovf;

  always #2.5 clk = ~clk;

  trace_line_packer uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .evt_i(evt),
    .evt_info_i(info), .evt_info2_i(info2), .evt_addr_i(addr),
    .evt_data_i(data), .evt_word_i(word), .flush_i(flush),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .cnt_o(cnt), .line_vld_o(vld), .line_pair_o(pair), .ovf_o(ovf)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] md, input logic ev, input logic fl, input int k);
    logic        mc, det, e_wr, e_pair;
    logic [6:0]  bc, bn;
    logic [63:0] e_line;
    logic [5:0]  e_addr;
    string       t;
    mode = md; evt = ev; flush = fl;
    info  = 8'(k * 29 + 3 * md);
    info2 = 8'(k * 13 + 7);
    addr  = 24'(k * 24'h010203) ^ 24'hA5A55A;
    data  = 16'(k * 16'h1357) ^ 16'h8001;
    word  = k[0];
    @(negedge clk);
    mc = (md != m_prev); m_prev = md;
    det = (md == 2'd3);
    bc = mc ? 7'd0 : m_cnt;
    bn = bc; e_wr = 1'b0; e_pair = 1'b0; e_line = '0; e_addr = bc[6:1];
    t = det ? "R5" : "R2";
    if (ev) begin
      if (det) begin
        e_wr = 1'b1; bn = bc + 7'd2;
        e_line = {info, addr, word ? data[15:8] : 8'h00, data[7:0], info2, 8'h00};
        t = word ? "R7" : "R6";
      end else if (!bc[0]) begin
        m_stage = {info, addr}; bn = bc + 7'd1;
      end else begin
        e_wr = 1'b1; e_pair = 1'b1; bn = bc + 7'd1;
        e_line = {info, addr, m_stage}; t = "R3";
      end
    end else if (fl && !det && bc[0]) begin
      e_wr = 1'b1; bn = bc + 7'd1; e_line = {32'h0, m_stage}; t = "R9";
    end else if (fl) begin
      t = "R9";
    end
    if (e_wr) begin
      m_vld[e_addr] = 1'b1; m_pair[e_addr] = e_pair;
      if (e_addr == 6'd63) m_ovf = 1'b1;
    end
    m_cnt = bn;
    chk({t, " wr_en"}, 64'(wr_en), 64'(e_wr));
    if (e_wr) begin
      chk({t, " addr"}, 64'(wr_addr), 64'(e_addr));
      chk({t, " data"}, wr_data, e_line);
      chk("R8 valid flag", 64'(vld[e_addr]), 64'h1);
      chk("R3 pair flag", 64'(pair[e_addr]), 64'(e_pair));
    end
    chk(det ? "R5 counter" : "R2 counter", 64'(cnt), 64'(bn));
    chk("R11 overflow", 64'(ovf), 64'(m_ovf));
    evt = 1'b0; flush = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nbad++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'd0; evt = 1'b0; flush = 1'b0; word = 1'b0;
    info = '0; info2 = '0; addr = '0; data = '0;
    m_prev = 2'd0; m_cnt = '0; m_stage = '0; m_vld = '0; m_pair = '0; m_ovf = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cnt", 64'(cnt), 64'h0);
    chk("R1 wr_en", 64'(wr_en), 64'h0);
    chk("R1 vld", vld, 64'h0);
    chk("R1 pair", pair, 64'h0);
    chk("R1 ovf", 64'(ovf), 64'h0);

    // R4: each compact mode, odd event count, flush, idle flush, flush with event
    for (int md = 0; md < 3; md++) begin
      for (int k = 0; k < 21; k++) step(2'(md), 1'b1, 1'b0, k + 40 * md);
      step(2'(md), 1'b0, 1'b1, 0);
      step(2'(md), 1'b0, 1'b1, 1);
      step(2'(md), 1'b1, 1'b0, 5);
      step(2'(md), 1'b1, 1'b1, 6);
      chk("R4 counter after mode run", 64'(cnt), 64'd24);
    end

    // R10: switch mode with an entry staged
    step(2'd0, 1'b1, 1'b0, 77);
    step(2'd1, 1'b0, 1'b0, 0);
    chk("R10 counter cleared", 64'(cnt), 64'h0);
    step(2'd1, 1'b0, 1'b1, 0);
    chk("R10 staged entry dropped", 64'(wr_en), 64'h0);

    // detailed sweep, byte and word alternating, wraps twice
    for (int k = 0; k < 140; k++) step(2'd3, 1'b1, 1'b0, k);
    step(2'd3, 1'b0, 1'b1, 0);
    chk("R11 overflow after wrap", 64'(ovf), 64'h1);

    // compact wrap
    for (int k = 0; k < 132; k++) step(2'd2, 1'b1, 1'b0, k + 300);
    chk("R8 valid vector", vld, m_vld);
    chk("R3 pair vector", pair, m_pair);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule